// File: doc/BRIEF.md
# Flow-Tuple Policy Cache

This block remembers network flows that a slow software inspector has already approved. Each stored entry is a complete flow tuple: a virtual path and virtual channel pair, source and destination IPv4 addresses, source and destination transport ports, and a protocol number. A lookup presents one tuple and gets back a registered one-bit verdict. A hit means the packet may pass. A miss means the last cell of the packet must be held back while the slow path decides.

On a miss, the block also raises a request that carries the full tuple to the slow-path inspector, using a valid/ready handshake. When the inspector approves a flow, it writes the tuple back through the insert port, so later packets of that flow hit. All valid entries are compared in parallel. Empty entries are filled first. Once the table is full, the entry that was written longest ago is overwritten. Lookup hits do not change that order, which keeps the replacement logic to a single pointer.

Top module: `flow_policy_cache`

## Requirements
- R1: A tuple is packed as a 132-bit vector, most significant field first: {vpi[11:0], vci[15:0], src_ip[31:0], dst_ip[31:0], src_port[15:0], dst_port[15:0], proto[7:0]}, so proto occupies bits 7:0 and vpi bits 131:120. A lookup passes only when every field equals a stored valid entry; a difference in any single field gives a miss.
- R2: `vd_valid_o` is high in exactly the cycle after a cycle with `lk_valid_i` high. `vd_pass_o` is 1 for a hit and 0 for a hold in that cycle.
- R3: A reset clears every entry's valid bit and drops both `vd_valid_o` and `mr_valid_o`; the first lookup after reset misses.
- R4: A missing lookup raises `mr_valid_o` in the same cycle as its verdict, with `mr_tuple_o` equal to the looked-up tuple. Both stay unchanged while `mr_ready_i` is low. The request is retired at the clock edge where valid and ready are both high.
- R5: A miss that occurs while an earlier request is pending and not being accepted still returns a hold verdict, but it does not replace the pending request.
- R6: An inserted tuple hits on later lookups. When a lookup and an insert occur in the same cycle, the lookup is judged against the table as it was before that insert.
- R7: Inserts fill invalid entries, lowest index first. DEPTH distinct inserts after reset all remain present.
- R8: When the table is full, a new tuple overwrites the entry that was inserted earliest. Lookup hits do not change this order.
- R9: Inserting a tuple that is already present neither adds an entry nor advances the replacement order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request strobe |
| lk_tuple_i | input | 132 | Tuple to look up (R1 packing) |
| vd_valid_o | output | 1 | Verdict valid, one cycle after lookup |
| vd_pass_o | output | 1 | 1 = pass (hit), 0 = hold last cell (miss) |
| mr_valid_o | output | 1 | Slow-path inspection request pending |
| mr_ready_i | input | 1 | Slow path accepts the request |
| mr_tuple_o | output | 132 | Tuple to inspect |
| ins_valid_i | input | 1 | Insert strobe from the slow path |
| ins_tuple_i | input | 132 | Approved tuple to store |

## Verification
The bench builds the cache with DEPTH=4. With that depth, a pool of eight random tuples overflows the table within a few inserts, so eviction, refill and hit-after-eviction happen hundreds of times in the random phase. The small depth also keeps directed sequences short, so a single sequence can show that the oldest entry leaves first even after it was recently hit, and that a duplicate insert does not move the replacement pointer. The full 132-bit tuple width is kept, so every field can be perturbed on its own.

// File: rtl/flowcache_pkg.sv
// Shared widths for the flow-tuple policy cache.
// Assumes IPv4 addresses and a cell header with 12-bit path and 16-bit channel ids.
package flowcache_pkg;
    localparam int VPI_W   = 12;
    localparam int VCI_W   = 16;
    localparam int IP_W    = 32;
    localparam int PORT_W  = 16;
    localparam int PROTO_W = 8;
    localparam int TUPLE_W = VPI_W + VCI_W + 2 * IP_W + 2 * PORT_W + PROTO_W;

    typedef struct packed {
        logic [VPI_W-1:0]   vpi;
        logic [VCI_W-1:0]   vci;
        logic [IP_W-1:0]    src_ip;
        logic [IP_W-1:0]    dst_ip;
        logic [PORT_W-1:0]  src_port;
        logic [PORT_W-1:0]  dst_port;
        logic [PROTO_W-1:0] proto;
    } flow_tuple_t;
endpackage

// File: rtl/fc_entry_store.sv
// Entry storage with two parallel comparators per entry: one for lookups and
// one for inserts. Assumes at most one write-enable bit is set per cycle.
// Data words are not reset; only their valid bits are.
module fc_entry_store
    import flowcache_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  flow_tuple_t        lk_tuple,
    input  flow_tuple_t        ins_tuple,
    input  logic [DEPTH-1:0]   wr_en,
    output logic [DEPTH-1:0]   lk_hit,
    output logic [DEPTH-1:0]   ins_hit,
    output logic [DEPTH-1:0]   valid_vec
);
    flow_tuple_t entry_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Store the insert tuple and mark the entry valid when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[g] <= 1'b0;
            end else if (wr_en[g]) begin
                valid_vec[g] <= 1'b1;
            end
        end

        // Capture data independently of reset.
        always_ff @(posedge clk) begin
            if (wr_en[g]) begin
                entry_q[g] <= ins_tuple;
            end
        end

        // Full-tuple equality for both ports.
        always_comb begin
            lk_hit[g]  = valid_vec[g] && (entry_q[g] == lk_tuple);
            ins_hit[g] = valid_vec[g] && (entry_q[g] == ins_tuple);
        end
    end

    // R9: no duplicate entries, so at most one entry matches a lookup.
    assert_single_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit));

    // R7: valid bits never drop outside reset.
    assert_valid_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ins_hit == ins_hit |=> (valid_vec & $past(valid_vec)) == $past(valid_vec));

    // Write enables select at most one entry.
    assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));
endmodule

// File: rtl/fc_victim_pick.sv
// Chooses the entry for a new insert: the lowest invalid entry if one exists,
// otherwise the entry at the FIFO pointer, which then advances. Assumes no
// entry is invalidated except by reset, so invalid entries fill in index order
// and the pointer, which stays at zero until the table is full, always marks
// the oldest entry.
module fc_victim_pick #(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_fire,
    input  logic [DEPTH-1:0] valid_vec,
    output logic [DEPTH-1:0] wr_en
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] free_idx;
    logic             any_free;

    // Lowest-index invalid entry.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                any_free = 1'b1;
                free_idx = PTR_W'(i);
            end
        end
    end

    // One-hot write select from the free slot or the FIFO pointer.
    always_comb begin
        wr_en = '0;
        if (ins_fire) begin
            wr_en[any_free ? free_idx : ptr_q] = 1'b1;
        end
    end

    // Advance the FIFO pointer only when a valid entry is overwritten.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ins_fire && !any_free) begin
            ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    // R7: while a free entry exists, the pointer does not move.
    assert_fill_before_evict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_fire && any_free) |=> $stable(ptr_q));

    // R9: with no new tuple, nothing is written and the order is kept.
    assert_dup_keeps_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_fire |=> $stable(ptr_q) && $stable(valid_vec));
endmodule

// File: rtl/fc_miss_slot.sv
// A single-entry holding register for the slow-path request. A new miss is
// loaded when the slot is empty or is being accepted in the same cycle;
// otherwise the new miss is dropped and the pending request is kept.
module fc_miss_slot #(
    parameter int WIDTH = 132
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [WIDTH-1:0] req_data
);
    logic can_load;

    // Slot is free now or empties at this edge.
    always_comb can_load = !req_valid || req_ready;

    // Hold, replace or retire the pending request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
        end else if (load && can_load) begin
            req_valid <= 1'b1;
        end else if (req_ready) begin
            req_valid <= 1'b0;
        end
    end

    // Tuple register, written only with the valid flag.
    always_ff @(posedge clk) begin
        if (load && can_load) begin
            req_data <= load_data;
        end
    end

    // R4: a stalled request keeps its valid flag and tuple.
    assert_req_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid && $stable(req_data));

    // R5: a miss that arrives against a stalled request does not replace it.
    assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && req_valid && !req_ready) |=> $stable(req_data));
endmodule

// File: rtl/flow_policy_cache.sv
// Fully associative cache of approved flow tuples. A lookup returns a
// registered pass/hold verdict one cycle later, and a miss also queues a
// slow-path request. Inserts from the slow path fill free entries first and
// then replace entries in insertion order. A lookup and an insert in the same
// cycle both see the table as it was before that cycle's write.
module flow_policy_cache
    import flowcache_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid_i,
    input  logic [TUPLE_W-1:0] lk_tuple_i,
    output logic               vd_valid_o,
    output logic               vd_pass_o,
    output logic               mr_valid_o,
    input  logic               mr_ready_i,
    output logic [TUPLE_W-1:0] mr_tuple_o,
    input  logic               ins_valid_i,
    input  logic [TUPLE_W-1:0] ins_tuple_i
);
    logic [DEPTH-1:0] lk_hit;
    logic [DEPTH-1:0] ins_hit;
    logic [DEPTH-1:0] valid_vec;
    logic [DEPTH-1:0] wr_en;
    logic             lk_found;
    logic             ins_fire;
    logic             miss_now;

    fc_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_tuple  (flow_tuple_t'(lk_tuple_i)),
        .ins_tuple (flow_tuple_t'(ins_tuple_i)),
        .wr_en     (wr_en),
        .lk_hit    (lk_hit),
        .ins_hit   (ins_hit),
        .valid_vec (valid_vec)
    );

    // Reduce match vectors; a tuple already present is not inserted again.
    always_comb begin
        lk_found = |lk_hit;
        ins_fire = ins_valid_i && !(|ins_hit);
        miss_now = lk_valid_i && !lk_found;
    end

    fc_victim_pick #(.DEPTH(DEPTH)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_fire  (ins_fire),
        .valid_vec (valid_vec),
        .wr_en     (wr_en)
    );

    // Register the verdict one cycle after the lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vd_valid_o <= 1'b0;
            vd_pass_o  <= 1'b0;
        end else begin
            vd_valid_o <= lk_valid_i;
            vd_pass_o  <= lk_valid_i && lk_found;
        end
    end

    fc_miss_slot #(.WIDTH(TUPLE_W)) u_miss (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (miss_now),
        .load_data (lk_tuple_i),
        .req_valid (mr_valid_o),
        .req_ready (mr_ready_i),
        .req_data  (mr_tuple_o)
    );

    // R2: a verdict follows every lookup by exactly one cycle.
    assert_verdict_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_i |=> vd_valid_o);
    assert_no_spurious_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |=> !vd_valid_o && !vd_pass_o);

    // R4: a miss against a free or draining slot raises the request with its tuple.
    assert_miss_requests_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_now && (!mr_valid_o || mr_ready_i)) |=>
            mr_valid_o && !vd_pass_o && (mr_tuple_o == $past(lk_tuple_i)));

    // R6: an insert of a new tuple makes it present on the next cycle.
    assert_insert_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid_i |=> (|ins_hit) || (ins_tuple_i != $past(ins_tuple_i)));
endmodule

// File: tb/flow_policy_cache_tb_top.sv
// Bench for the flow-tuple policy cache, built with DEPTH=4. A reference
// model kept in bench functions tracks valid bits, insertion order and the
// FIFO pointer from the requirements alone.
module flow_policy_cache_tb_top;
    import flowcache_pkg::*;

    localparam int D = 4;
    localparam int POOL = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               lk_valid_i = 1'b0;
    logic [TUPLE_W-1:0] lk_tuple_i = '0;
    logic               vd_valid_o;
    logic               vd_pass_o;
    logic               mr_valid_o;
    logic               mr_ready_i = 1'b1;
    logic [TUPLE_W-1:0] mr_tuple_o;
    logic               ins_valid_i = 1'b0;
    logic [TUPLE_W-1:0] ins_tuple_i = '0;

    int checks = 0;
    int errors = 0;

    logic [TUPLE_W-1:0] m_tup [D];
    logic               m_val [D];
    int                 m_ptr;
    logic [TUPLE_W-1:0] pool [POOL];

    flow_policy_cache #(.DEPTH(D)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid_i (lk_valid_i),
        .lk_tuple_i (lk_tuple_i),
        .vd_valid_o (vd_valid_o),
        .vd_pass_o  (vd_pass_o),
        .mr_valid_o (mr_valid_o),
        .mr_ready_i (mr_ready_i),
        .mr_tuple_o (mr_tuple_o),
        .ins_valid_i(ins_valid_i),
        .ins_tuple_i(ins_tuple_i)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic model_hit(logic [TUPLE_W-1:0] t);
        for (int i = 0; i < D; i++)
            if (m_val[i] && m_tup[i] == t) return 1'b1;
        return 1'b0;
    endfunction

    function automatic void model_insert(logic [TUPLE_W-1:0] t);
        if (model_hit(t)) return;
        for (int i = 0; i < D; i++) begin
            if (!m_val[i]) begin
                m_val[i] = 1'b1;
                m_tup[i] = t;
                return;
            end
        end
        m_tup[m_ptr] = t;
        m_ptr = (m_ptr + 1) % D;
    endfunction

    function automatic logic [TUPLE_W-1:0] rand_tuple();
        logic [159:0] r;
        r = {$urandom, $urandom, $urandom, $urandom, $urandom};
        return r[TUPLE_W-1:0];
    endfunction

    task automatic check(string req, logic [TUPLE_W-1:0] act, logic [TUPLE_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lk_valid_i = 1'b0;
        ins_valid_i = 1'b0;
        mr_ready_i = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < D; i++) m_val[i] = 1'b0;
        m_ptr = 0;
    endtask

    // One cycle of stimulus; verdict and request are sampled at the next negedge.
    task automatic step(bit do_lk, logic [TUPLE_W-1:0] lt, bit do_ins,
                        logic [TUPLE_W-1:0] it, string req);
        logic exp_pass;
        exp_pass = model_hit(lt);
        lk_valid_i = do_lk;
        lk_tuple_i = lt;
        ins_valid_i = do_ins;
        ins_tuple_i = it;
        if (do_ins) model_insert(it);
        @(negedge clk);
        lk_valid_i = 1'b0;
        ins_valid_i = 1'b0;
        check({req, " R2 verdict valid"}, TUPLE_W'(vd_valid_o), TUPLE_W'(do_lk));
        if (do_lk) begin
            check({req, " verdict"}, TUPLE_W'(vd_pass_o), TUPLE_W'(exp_pass));
            if (!exp_pass && mr_ready_i) begin
                check({req, " R4 request valid"}, TUPLE_W'(mr_valid_o), TUPLE_W'(1));
                check({req, " R4 request tuple"}, mr_tuple_o, lt);
            end
        end
    endtask

    initial begin
        logic [TUPLE_W-1:0] base;
        int seed_ret;
        seed_ret = $urandom(32'd20240611);
        for (int i = 0; i < POOL; i++) pool[i] = rand_tuple();

        // R3: reset state.
        do_reset();
        check("R3 verdict low", TUPLE_W'(vd_valid_o), '0);
        check("R3 request low", TUPLE_W'(mr_valid_o), '0);
        step(1, pool[0], 0, '0, "R3 first lookup misses");

        // R1: field packing, one field perturbed at a time.
        base = pool[1];
        step(0, '0, 1, base, "R6 insert");
        step(1, base, 0, '0, "R6 hit after insert");
        begin
            int offs [7] = '{0, 8, 24, 40, 72, 104, 120};
            for (int k = 0; k < 7; k++)
                step(1, base ^ (TUPLE_W'(1) << offs[k]), 0, '0, "R1 field mismatch");
        end

        // R6: same-cycle lookup and insert sees the old table.
        step(1, pool[2], 1, pool[2], "R6 same-cycle lookup");
        step(1, pool[2], 0, '0, "R6 later lookup");

        // R7/R8: fill, hit the oldest, then evict it anyway.
        do_reset();
        for (int i = 0; i < D; i++) step(0, '0, 1, pool[i], "R7 fill");
        for (int i = 0; i < D; i++) step(1, pool[i], 0, '0, "R7 all present");
        step(1, pool[0], 0, '0, "R8 hit oldest");
        step(0, '0, 1, pool[4], "R8 insert on full");
        step(1, pool[0], 0, '0, "R8 oldest evicted");
        step(1, pool[1], 0, '0, "R8 second kept");
        step(1, pool[4], 0, '0, "R8 newest present");

        // R9: duplicate insert keeps order.
        do_reset();
        step(0, '0, 1, pool[0], "R9 first");
        step(0, '0, 1, pool[0], "R9 duplicate while free");
        for (int i = 1; i < D; i++) step(0, '0, 1, pool[i], "R9 fill");
        for (int i = 0; i < D; i++) step(1, pool[i], 0, '0, "R9 no slot wasted");
        step(0, '0, 1, pool[1], "R9 duplicate when full");
        step(0, '0, 1, pool[5], "R9 evict");
        step(1, pool[0], 0, '0, "R9 oldest gone");
        step(1, pool[1], 0, '0, "R9 duplicate did not move pointer");

        // R4/R5: back-pressure on the request.
        do_reset();
        mr_ready_i = 1'b0;
        step(1, pool[6], 0, '0, "R4 stalled miss");
        check("R4 request raised", TUPLE_W'(mr_valid_o), TUPLE_W'(1));
        check("R4 request tuple", mr_tuple_o, pool[6]);
        step(1, pool[7], 0, '0, "R5 second miss");
        check("R5 pending kept valid", TUPLE_W'(mr_valid_o), TUPLE_W'(1));
        check("R5 pending tuple kept", mr_tuple_o, pool[6]);
        @(negedge clk);
        check("R4 held while not ready", mr_tuple_o, pool[6]);
        mr_ready_i = 1'b1;
        @(negedge clk);
        check("R4 retired on accept", TUPLE_W'(mr_valid_o), '0);

        // Random mix of lookups and inserts against the model.
        do_reset();
        for (int n = 0; n < 600; n++) begin
            int op;
            op = $urandom_range(0, 3);
            step(op != 1, pool[$urandom_range(0, POOL - 1)],
                 op != 0, pool[$urandom_range(0, POOL - 1)], "R8 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule